// File: doc/BRIEF.md
# NRZI Symbol Serializer Transmitter

This block turns 5-bit coded symbols, presented in parallel once per symbol clock, into a serial NRZI bit stream at five times the symbol rate. A symbol is captured on the rising edge of the symbol clock. It is then sent most significant bit first, one bit per bit clock period. Each NRZ 1 flips the line level and each 0 leaves it alone.

Two serial outputs carry the same stream. The line output goes to the medium and the loopback output goes to a local receiver. Each has its own active-low control that forces it to a static low level. Forcing an output low only masks it: the internal NRZI level keeps following the data, so the stream resumes in phase when the output is released. In test mode the transmitter-off pin stops gating the line output and instead serves as the bit clock, while the normal bit clock input is ignored. Every symbol clock rise pulls the bit counter back to the load position, so the next bit starts the symbol just captured.

All clock-like inputs are sampled by a free-running core clock. That clock must run at more than twice the bit rate, and the block acts on the rising edges it detects in those samples.

Top module: `nrzi_symbol_tx`

## Requirements
- R1: On a core clock edge that sees a rising edge of `sym_clk`, the value on `sym_in` is captured as the pending symbol.
- R2: A 5-position bit counter advances by one on each detected bit clock rise and wraps after position 4. At position 0 the pending symbol is loaded into the shifter.
- R3: The loaded symbol is sent bit 4 first and bit 0 last, one bit per bit clock rise. When the symbol and bit clocks rise together, the symbol captured at one symbol clock rise is sent during the five bit periods that begin at the next five bit clock rises.
- R4: The NRZI level toggles at a bit clock rise whose NRZ bit is 1 and holds when it is 0. It never changes without a detected bit clock rise.
- R5: In normal mode (`test_mode`=0), `line_out` is 0 while `tx_off_n`=0 and follows the NRZI level while `tx_off_n`=1.
- R6: `loop_out` follows the NRZI level while `loop_en_n`=0 and is 0 while `loop_en_n`=1.
- R7: Forcing either output low does not disturb the NRZI level. After release, the output shows the level that an unforced stream would have.
- R8: In test mode (`test_mode`=1), rises of `tx_off_n` act as the bit clock and `bit_clk` has no effect. `line_out` follows the NRZI level whatever the value of `tx_off_n`.
- R9: A `sym_clk` rise with no coincident bit clock rise puts the bit counter at position 0. The next bit clock rise sends bit 4 of the newly captured symbol.
- R10: A synchronous reset (`rst_n`=0) clears the NRZI level to 0, the counter to position 0 and the pending symbol to 0, so both outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core sampling clock, faster than twice the bit rate |
| rst_n | input | 1 | Synchronous reset, active low |
| sym_clk | input | 1 | Symbol clock; a rising edge captures `sym_in` and realigns the counter |
| sym_in | input | SYM_W | Coded symbol, bit SYM_W-1 sent first |
| bit_clk | input | 1 | Bit clock at SYM_W times the symbol rate (normal mode) |
| tx_off_n | input | 1 | Normal mode: forces `line_out` low when 0. Test mode: bit clock |
| loop_en_n | input | 1 | Loopback enable, active low; 1 forces `loop_out` low |
| test_mode | input | 1 | Selects test mode |
| line_out | output | 1 | Serial NRZI line output |
| loop_out | output | 1 | Serial NRZI loopback output |

## Verification
The hardest situation to reach from the ports is a symbol clock rise that arrives partway through a symbol. With aligned clocks that rise never moves the counter. The bench therefore switches to test mode and steps bits by hand through `tx_off_n`. It sends two bits of one symbol and then raises only `sym_clk` with a new symbol, so the bit that follows must be bit 4 of the new symbol. In the same mode it pulses `bit_clk` while a 1 is pending and checks that the line level does not move.

// File: rtl/nrzi_symbol_tx.sv
module nrzi_symbol_tx #(
  parameter int SYM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_clk,
  input  logic [SYM_W-1:0] sym_in,
  input  logic             bit_clk,
  input  logic             tx_off_n,
  input  logic             loop_en_n,
  input  logic             test_mode,
  output logic             line_out,
  output logic             loop_out
);
  localparam int CW = (SYM_W > 2) ? $clog2(SYM_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(SYM_W - 1);

  logic             sym_q, src_q, lvl;
  logic [SYM_W-1:0] in_reg, sh;
  logic [CW-1:0]    cnt;

  wire bit_src  = test_mode ? tx_off_n : bit_clk;
  wire sym_rise = sym_clk & ~sym_q;
  wire bit_rise = bit_src & ~src_q;
  wire at_load  = (cnt == '0);
  wire cur_bit  = at_load ? in_reg[SYM_W-1] : sh[SYM_W-2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym_q  <= 1'b0;
      src_q  <= 1'b0;
      in_reg <= '0;
      sh     <= '0;
      cnt    <= '0;
      lvl    <= 1'b0;
    end else begin
      sym_q <= sym_clk;
      src_q <= bit_src;
      if (sym_rise) in_reg <= sym_in;
      if (bit_rise) begin
        sh  <= at_load ? in_reg : {sh[SYM_W-2:0], 1'b0};
        lvl <= lvl ^ cur_bit;
      end
      if (sym_rise)      cnt <= '0;
      else if (bit_rise) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign line_out = lvl & (test_mode | tx_off_n);
  assign loop_out = lvl & ~loop_en_n;

  // R1: capture on symbol clock rise
  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    sym_rise |=> in_reg == $past(sym_in));

  // R2: counter stays inside the symbol
  a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R2: load at the boundary position
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_rise && at_load) |=> sh == $past(in_reg));

  // R4: level moves only on a bit clock rise
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_rise |=> $stable(lvl));

  // R6: loopback mirrors an ungated line output
  a_r6_loop_match: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_en_n && (test_mode || tx_off_n)) |-> loop_out == line_out);

  // R9: symbol clock rise realigns the counter
  a_r9_realign: assert property (@(posedge clk) disable iff (!rst_n)
    sym_rise |=> cnt == '0);
endmodule

// File: tb/nrzi_symbol_tx_bench.sv
module nrzi_symbol_tx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_clk = 1'b0;
  logic [4:0] sym_in = '0;
  logic bit_clk = 1'b0;
  logic tx_off_n = 1'b1;
  logic loop_en_n = 1'b0;
  logic test_mode = 1'b0;
  logic line_out, loop_out;

  int checks = 0;
  int fails = 0;
  logic lvl_m = 1'b0;
  logic ctl_off_n = 1'b1;
  bit done = 0;

  always #10 clk = ~clk;

  nrzi_symbol_tx #(.SYM_W(5)) u_nrzi_symbol_tx (
    .clk(clk), .rst_n(rst_n), .sym_clk(sym_clk), .sym_in(sym_in),
    .bit_clk(bit_clk), .tx_off_n(tx_off_n), .loop_en_n(loop_en_n),
    .test_mode(test_mode), .line_out(line_out), .loop_out(loop_out));

  // {tx_off_n, loop_en_n, symbol}
  localparam logic [6:0] VEC [12] = '{
    {2'b10, 5'b11111}, {2'b10, 5'b10101}, {2'b10, 5'b00000}, {2'b10, 5'b11000},
    {2'b00, 5'b10110}, {2'b11, 5'b01101}, {2'b01, 5'b11111}, {2'b10, 5'b00111},
    {2'b10, 5'b10001}, {2'b10, 5'b01010}, {2'b10, 5'b11011}, {2'b10, 5'b00100}};

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic slot(input logic symr, input logic [4:0] s, input logic tm,
                      input logic nrz, input string ltag, input string otag);
    @(negedge clk);
    if (tm) tx_off_n = 1'b1; else bit_clk = 1'b1;
    if (symr) begin sym_in = s; sym_clk = 1'b1; end
    repeat (2) @(negedge clk);
    lvl_m = lvl_m ^ nrz;
    check(ltag, line_out, (tm || ctl_off_n) ? lvl_m : 1'b0);
    check(otag, loop_out, !loop_en_n ? lvl_m : 1'b0);
    @(negedge clk);
    if (tm) tx_off_n = 1'b0; else bit_clk = 1'b0;
    sym_clk = 1'b0;
    repeat (2) @(negedge clk);
    if (tm) check("R8 line ungated by low tx_off_n", line_out, lvl_m);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [4:0] prev, cur;
    logic prev_forced;
    string lt, ot;
    repeat (3) @(negedge clk);
    check("R10 line after reset", line_out, 1'b0);
    check("R10 loop after reset", loop_out, 1'b0);
    rst_n = 1'b1;
    prev = '0;
    prev_forced = 1'b0;
    for (int n = 0; n <= 12; n++) begin
      if (n < 12) begin
        cur = VEC[n][4:0];
        ctl_off_n = VEC[n][6];
        tx_off_n  = VEC[n][6];
        loop_en_n = VEC[n][5];
      end
      lt = !ctl_off_n ? "R5 line forced" : (prev_forced ? "R7 line after release" : "R4 line level");
      ot = loop_en_n ? "R6 loop forced" : "R1 R2 R3 loop stream";
      slot(n < 12, cur, 1'b0, prev[0], lt, ot);
      if (n < 12) begin
        for (int b = 1; b < 5; b++)
          slot(1'b0, '0, 1'b0, cur[5-b], lt, ot);
        prev_forced = !ctl_off_n || loop_en_n;
        prev = cur;
      end
    end

    @(negedge clk);
    rst_n = 1'b0;
    lvl_m = 1'b0;
    @(negedge clk);
    check("R10 line during reset", line_out, 1'b0);

    tx_off_n = 1'b0;
    test_mode = 1'b1;
    loop_en_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    slot(1'b1, 5'b10110, 1'b1, 1'b0, "R8 test first slot", "R8 test loop");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      bit_clk = 1'b1;
      repeat (2) @(negedge clk);
      check("R8 bit_clk ignored", line_out, lvl_m);
      bit_clk = 1'b0;
      repeat (2) @(negedge clk);
    end
    slot(1'b0, '0, 1'b1, 1'b1, "R8 test bit4", "R8 test loop");
    slot(1'b0, '0, 1'b1, 1'b0, "R8 test bit3", "R8 test loop");
    @(negedge clk);
    sym_in = 5'b11001;
    sym_clk = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 realign no level change", line_out, lvl_m);
    sym_clk = 1'b0;
    repeat (2) @(negedge clk);
    slot(1'b0, '0, 1'b1, 1'b1, "R9 new symbol bit4", "R9 loop");
    slot(1'b0, '0, 1'b1, 1'b1, "R9 new symbol bit3", "R9 loop");
    slot(1'b0, '0, 1'b1, 1'b0, "R9 new symbol bit2", "R9 loop");
    slot(1'b0, '0, 1'b1, 1'b0, "R9 new symbol bit1", "R9 loop");
    slot(1'b0, '0, 1'b1, 1'b1, "R9 new symbol bit0", "R9 loop");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule